// File: doc/BRIEF.md
# Bus-Cycle Single-Step Clock Gate

This block sits between a free-running oscillator and the clock pin of a processor. It lets a bench or lab board freeze the processor in the middle of a bus access so that the address, data and strobe lines can be inspected at leisure. In run mode the oscillator passes straight through. In step mode each press of a debounced step button releases clock pulses until the processor has emitted its address-latch pulse. The gate then holds the clock off a fixed number of cycles after that pulse ends. The stop point is tied to the bus cycle, not to a clock count, so instructions of any length stop at the same phase of their next access.

The enable that gates the clock is registered on the falling oscillator edge and ANDed with the oscillator. It can therefore change only while the oscillator is low. The gated clock never shows a shortened high phase, and it rests low when stopped.

Top module: `step_clock_gate`

## Requirements
- R1: With `run_mode` high and settled, `gclk` equals `osc_clk` on every phase.
- R2: While stopped in step mode, `gclk` stays low and the processor receives no rising edge.
- R3: In step mode, once the processor's address-latch strobe `ale` falls at a `gclk` rising edge, exactly two further `gclk` rising edges are delivered and the clock is then held off (`TAIL_CLKS` = 2).
- R4: Every high phase of `gclk` lasts exactly one oscillator high phase, and every low phase is a whole number of oscillator periods plus one low phase; the gating enable changes only while `osc_clk` is low.
- R5: A step is triggered by a rising edge of `step_req` only; holding the request high produces a single burst, which covers one bus cycle.
- R6: A step request arriving while a burst is still in progress is ignored and does not extend or repeat the burst.
- R7: Raising `run_mode` while stopped takes effect at the next falling edge of `osc_clk`; the first following oscillator high phase appears whole on `gclk`.
- R8: Lowering `run_mode` while running lets the current bus cycle complete to the same stop point as R3 (two rising edges after the `ale` fall), then stops.
- R9: While `rst` is high `gclk` is low, whatever `run_mode` is; after reset in step mode the clock stays stopped until a step request.
- R10: The stop rule of R3 holds for long bus cycles: a burst for a twelve-clock instruction delivers twelve rising edges and ends two edges after its `ale` fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling oscillator edge |
| run_mode | input | 1 | 1 = free run, 0 = single-step |
| step_req | input | 1 | Debounced step button, active high |
| ale | input | 1 | Address-latch strobe from the processor, clocked by `gclk` |
| gclk | output | 1 | Gated clock to the processor |

## Verification
The bench drives a bus-cycle model whose address-latch pulse repeats every four or every twelve gated clocks. It counts gated rising edges per burst and after each strobe fall. A gate that stopped on a fixed count would deliver the wrong number of edges on the long cycle, and an off-by-one in the tail would leave one or three edges after the fall. Every gated high and low phase is timed against the oscillator, so an enable that moved while the clock was high shows up as a short pulse. Held buttons, a second press mid-burst and both mode switches catch a gate that steps twice, restarts its burst, cuts the bus cycle short or emits a partial first pulse.

// File: rtl/sscg_pkg.sv
package sscg_pkg;
  typedef enum logic [1:0] {
    ST_STOP    = 2'd0,
    ST_WAIT_HI = 2'd1,
    ST_WAIT_LO = 2'd2,
    ST_TAIL    = 2'd3
  } burst_st_t;
endpackage

// File: rtl/sscg_rise_det.sv
// Rising-edge detector on the falling oscillator edge.
module sscg_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(negedge clk) begin
    if (rst) din_q <= 1'b0;
    else     din_q <= din;
  end

  assign rise = din & ~din_q;
endmodule

// File: rtl/sscg_burst_fsm.sv
// Burst controller: decides, on each falling oscillator edge,
// whether the next oscillator high phase reaches the processor.
module sscg_burst_fsm
  import sscg_pkg::*;
#(
  parameter int TAIL_CLKS = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      run_mode,
  input  logic      start,
  input  logic      ale,
  output logic      en,
  output burst_st_t state
);
  localparam int CW = $clog2(TAIL_CLKS + 1);
  localparam logic [CW-1:0] TAIL_LOAD = CW'(TAIL_CLKS);
  localparam logic [CW-1:0] ONE       = CW'(1);

  logic [CW-1:0] tail_cnt;

  always_ff @(negedge clk) begin
    if (rst) begin
      state    <= ST_STOP;
      tail_cnt <= '0;
      en       <= 1'b0;
    end else if (run_mode) begin
      // Track bus phase while running so a switch to step mode
      // stops at the end of the current bus cycle.
      en       <= 1'b1;
      tail_cnt <= '0;
      state    <= ale ? ST_WAIT_LO : ST_WAIT_HI;
    end else begin
      unique case (state)
        ST_STOP: begin
          if (start) begin
            en    <= 1'b1;
            state <= ST_WAIT_HI;
          end else begin
            en <= 1'b0;
          end
        end
        ST_WAIT_HI: begin
          if (ale) state <= ST_WAIT_LO;
        end
        ST_WAIT_LO: begin
          if (!ale) begin
            state    <= ST_TAIL;
            tail_cnt <= TAIL_LOAD;
          end
        end
        ST_TAIL: begin
          if (tail_cnt <= ONE) begin
            en       <= 1'b0;
            tail_cnt <= '0;
            state    <= ST_STOP;
          end else begin
            tail_cnt <= tail_cnt - ONE;
          end
        end
        default: state <= ST_STOP;
      endcase
    end
  end
endmodule

// File: rtl/sscg_gate.sv
// Clock AND gate; enable is only ever updated while clk is low.
module sscg_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  assign gclk = clk & en;
endmodule

// File: rtl/step_clock_gate.sv
module step_clock_gate
  import sscg_pkg::*;
#(
  parameter int TAIL_CLKS = 2
) (
  input  logic osc_clk,
  input  logic rst,
  input  logic run_mode,
  input  logic step_req,
  input  logic ale,
  output logic gclk
);
  logic      req_rise;
  logic      gate_en;
  burst_st_t burst_state;

  sscg_rise_det u_req (
    .clk  (osc_clk),
    .rst  (rst),
    .din  (step_req),
    .rise (req_rise)
  );

  sscg_burst_fsm #(.TAIL_CLKS(TAIL_CLKS)) u_fsm (
    .clk      (osc_clk),
    .rst      (rst),
    .run_mode (run_mode),
    .start    (req_rise),
    .ale      (ale),
    .en       (gate_en),
    .state    (burst_state)
  );

  sscg_gate u_gate (
    .clk  (osc_clk),
    .en   (gate_en),
    .gclk (gclk)
  );
endmodule

// File: rtl/step_clock_gate_chk.sv
module step_clock_gate_chk #(
  parameter int TAIL_CLKS = 2
) (
  input logic osc_clk,
  input logic rst,
  input logic run_mode,
  input logic ale,
  input logic en,
  input logic gclk
);
  logic [2:0] cyc;

  always_ff @(negedge osc_clk) begin
    if (rst)              cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  // R4: enable moves only while the oscillator is low
  always @(en) begin
    a_r4_en_moves_low: assert (osc_clk == 1'b0)
      else $error("enable changed while oscillator high");
  end

  // R2: no pulse delivered -> processor strobe cannot move
  a_r2_frozen_bus: assert property (@(negedge osc_clk) disable iff (rst)
    (cyc >= 3'd2 && !en) |-> $stable(ale));

  // R7: run request opens the gate at the next falling edge
  a_r7_run_opens: assert property (@(negedge osc_clk) disable iff (rst)
    (cyc >= 3'd2 && run_mode) |=> en);

  // R3: two more pulses after the strobe fall, then closed
  generate
    if (TAIL_CLKS == 2) begin : g_tail2
      a_r3_two_after_fall: assert property (@(negedge osc_clk) disable iff (rst)
        (cyc >= 3'd6 && $past(ale, 4) && !$past(ale, 3)
         && !$past(run_mode, 4) && !$past(run_mode, 3)
         && !$past(run_mode, 2) && !$past(run_mode, 1))
        |-> ($past(en, 2) && $past(en, 1) && !en));
    end
  endgenerate
endmodule

bind step_clock_gate step_clock_gate_chk #(.TAIL_CLKS(TAIL_CLKS)) u_chk (
  .osc_clk  (osc_clk),
  .rst      (rst),
  .run_mode (run_mode),
  .ale      (ale),
  .en       (gate_en),
  .gclk     (gclk)
);

// File: tb/tb_step_clock_gate.sv
`timescale 1ns/1ps
module tb_step_clock_gate;
  logic osc_clk  = 1'b0;
  logic rst      = 1'b1;
  logic run_mode = 1'b0;
  logic step_req = 1'b0;
  logic ale      = 1'b0;
  logic gclk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 osc_clk = ~osc_clk;

  step_clock_gate dut (
    .osc_clk  (osc_clk),
    .rst      (rst),
    .run_mode (run_mode),
    .step_req (step_req),
    .ale      (ale),
    .gclk     (gclk)
  );

  // Bus-cycle model: strobe high for one clock every 'per' clocks
  int per   = 4;
  int phase = 3;
  int gpos  = 0;
  int tail  = 0;

  always @(posedge gclk) begin
    gpos <= gpos + 1;
    if (ale && phase != per - 1) tail <= 0;
    else                         tail <= tail + 1;
    ale   <= (phase == per - 1);
    phase <= (phase == per - 1) ? 0 : phase + 1;
  end

  // Phase-width monitor (R4)
  longint t_rise = 0, t_fall = 0;
  bit have_rise = 0, have_fall = 0;
  int glitch_err = 0;

  always @(posedge gclk) begin
    t_rise = $time;
    if (have_fall && ((t_rise - t_fall) % 20) != 10) glitch_err++;
    have_rise = 1;
  end
  always @(negedge gclk) begin
    if (have_rise) begin
      t_fall = $time;
      if ((t_fall - t_rise) != 10) glitch_err++;
      have_fall = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_edge();
    @(posedge osc_clk); #2;
  endtask

  task automatic mid_high();
    @(posedge osc_clk); #5;
  endtask

  task automatic press(input int hold);
    drive_edge(); step_req = 1'b1;
    repeat (hold) drive_edge();
    step_req = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; run_mode = 1'b1;
    repeat (3) mid_high();
    chk(gclk == 1'b0, "R9 low in reset", gclk, 0);
    drive_edge(); run_mode = 1'b0;
    repeat (2) drive_edge(); rst = 1'b0;
    begin
      int p0 = gpos;
      repeat (10) mid_high();
      chk(gpos == p0, "R9 stays stopped after reset", gpos - p0, 0);
      chk(gclk == 1'b0, "R2 rests low after reset", gclk, 0);
    end
  endtask

  task automatic step_and_check(input int exp_pulses, input string req);
    int p0 = gpos;
    press(1);
    repeat (exp_pulses + 10) mid_high();
    chk(gpos - p0 == exp_pulses, {req, " burst length"}, gpos - p0, exp_pulses);
    chk(tail == 2, {req, " edges after strobe fall"}, tail, 2);
  endtask

  task automatic t_short_steps();
    per = 4;
    step_and_check(4, "R3");
    for (int i = 0; i < 2; i++) step_and_check(4, "R5");
    begin
      int p0 = gpos;
      bit hi = 0;
      for (int i = 0; i < 6; i++) begin mid_high(); hi |= gclk; end
      chk(hi == 0 && gpos == p0, "R2 frozen between steps", gpos - p0, 0);
    end
  endtask

  task automatic t_held();
    int p0 = gpos;
    press(40);
    repeat (5) mid_high();
    chk(gpos - p0 == 4, "R5 held request single burst", gpos - p0, 4);
  endtask

  task automatic t_long();
    per = 12;
    step_and_check(12, "R10");
    step_and_check(12, "R10");
  endtask

  task automatic t_ignore();
    int p0 = gpos;
    press(1);
    repeat (4) drive_edge();
    press(1);
    repeat (40) mid_high();
    chk(gpos - p0 == 12, "R6 mid-burst request ignored", gpos - p0, 12);
    chk(tail == 2, "R6 stop point kept", tail, 2);
  endtask

  task automatic t_step_to_run();
    int p0;
    per = 4;
    drive_edge(); run_mode = 1'b1;
    mid_high();
    chk(gclk == 1'b1, "R7 first high phase after switch", gclk, 1);
    p0 = gpos;
    repeat (20) mid_high();
    chk(gpos - p0 == 20, "R1 every oscillator edge passed", gpos - p0, 20);
    @(negedge osc_clk); #5;
    chk(gclk == 1'b0, "R1 low phase follows oscillator", gclk, 0);
    mid_high();
    chk(gclk == 1'b1, "R1 high phase follows oscillator", gclk, 1);
  endtask

  task automatic t_run_to_step();
    int p0;
    drive_edge(); run_mode = 1'b0;
    repeat (15) mid_high();
    chk(tail == 2, "R8 stops two edges after strobe fall", tail, 2);
    p0 = gpos;
    repeat (10) mid_high();
    chk(gpos == p0, "R8 held after switch to step", gpos - p0, 0);
    step_and_check(4, "R8");
  endtask

  initial begin
    t_reset();
    t_short_steps();
    t_held();
    t_long();
    t_ignore();
    t_step_to_run();
    t_run_to_step();
    chk(glitch_err == 0, "R4 phase widths", glitch_err, 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule